// File: doc/BRIEF.md
# Handshake Command Receiver with Deferred Acknowledge

This block sits between a graphics board and a command executor. The graphics board presents one byte at a time on a parallel data bus and marks each byte with a low-going strobe. The receiver captures the byte on the strobe's falling edge and decodes the first byte of a command as an opcode. From the opcode it derives the frame length: one byte, or three bytes carrying a 16-bit operand. It presents the finished command to the executor and holds it until the executor reports completion. Opcodes above the legal range are folded to opcode 0.

Acknowledge pulses back to the graphics board are off after reset. They are enabled by the hello command (opcode 2). From then on, every completion reported by the executor produces one low pulse on the acknowledge line. The hello itself is acknowledged only when the executor reports it done. The executor does that once its startup sequence has finished, so the acknowledge for the hello comes late. A direction output is updated whenever a direction command (opcode 4) completes its frame.

The control is a four-state machine. WAIT_OP takes the opcode byte. A long opcode goes to WAIT_HI (the "long opcode" transition). A short opcode goes straight to PENDING (the "short frame" transition). WAIT_HI takes the operand high byte and moves to WAIT_LO. WAIT_LO takes the low byte and moves to PENDING (the "frame complete" transition). PENDING returns to WAIT_OP when the executor reports done (the "release" transition). A byte that arrives in PENDING takes the "drop" self-loop and raises the overflow flag.

Top module: `cmdrx_top`

## Requirements
- R1: One byte is captured per falling edge of `rx_strobe_n`. A strobe held low for many cycles still yields exactly one byte, and the rising edge captures nothing.
- R2: An opcode byte above 0x13 is forwarded as opcode 0, with 1-byte framing and operand 0.
- R3: Opcodes 0x03, 0x04 and 0x13 take three bytes; all other opcodes take one. `cmd_valid` stays low until the last byte of the frame has been captured.
- R4: In a 3-byte frame, byte 2 is the operand high byte and byte 3 is the low byte (03 04 D2 gives operand 0x04D2). A 1-byte command presents operand 0.
- R5: Once `cmd_valid` is high, it stays high with `cmd_op` and `cmd_arg` unchanged until `exec_done` is seen. It is low in the following cycle.
- R6: Before a hello command (opcode 2) has been received, `ack_n` never goes low, even though commands are still forwarded and completed.
- R7: Receiving a hello arms the acknowledge. From then on, each `exec_done` for a pending command produces exactly one low pulse of ACK_W cycles on `ack_n`, starting the cycle after `exec_done`. The hello itself is acknowledged only at its own `exec_done`.
- R8: When an opcode 4 frame completes, `dir_fwd` is set to 0 if operand bit 15 is 1, and to 1 otherwise. Other opcodes leave `dir_fwd` unchanged.
- R9: A byte strobed while a command is pending is discarded and sets `overflow`. The flag stays set until reset.
- R10: Reset discards any partial frame and clears the armed state and `overflow`. It drives `cmd_valid` to 0, `ack_n` to 1 and `dir_fwd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Byte from the graphics board, stable around the strobe's falling edge |
| rx_strobe_n | input | 1 | Byte strobe, active low, asynchronous to `clk` |
| exec_done | input | 1 | Executor has finished the pending command |
| cmd_valid | output | 1 | A complete command is pending |
| cmd_op | output | 5 | Opcode after folding, 0 to 0x13 |
| cmd_arg | output | 16 | Operand of a 3-byte command, otherwise 0 |
| dir_fwd | output | 1 | Direction: 1 forward, 0 reverse |
| ack_n | output | 1 | Acknowledge strobe to the graphics board, active low |
| overflow | output | 1 | Sticky: a byte was dropped while a command was pending |

## Verification
A state machine stuck in a wrong state shows up at the ports within one command. A frame-length error either shifts operand bytes into the next opcode or raises `cmd_valid` one or two bytes too early, and the next scoreboard compare exposes it. A fault in the armed flag shows as a missing or extra low pulse on `ack_n` within ACK_W+1 cycles of the `exec_done` that should have caused it. A bad overflow or direction register is visible on its own output as soon as the triggering byte has been taken.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
    localparam int MAX_OP = 19;
    localparam int OP_W   = $clog2(MAX_OP + 1);

    typedef enum logic [1:0] {
        ST_WAIT_OP,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_PENDING
    } rx_state_t;

    function automatic logic op_is_long(input logic [OP_W-1:0] op);
        return (op == OP_W'(3)) || (op == OP_W'(4)) || (op == OP_W'(19));
    endfunction
endpackage

// File: rtl/cmdrx_edge.sv
module cmdrx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else if (i == 0) sync_q[i] <= strobe_n;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[STAGES-1];
    end

    assign fall = last_q & ~sync_q[STAGES-1];

    // R1: a detected edge is a single-cycle event
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
    import cmdrx_pkg::*;
(
    input  logic [7:0]      byte_in,
    output logic [OP_W-1:0] op,
    output logic            long_frame
);
    always_comb begin
        if (byte_in > 8'(MAX_OP)) op = '0;
        else                      op = byte_in[OP_W-1:0];
        long_frame = op_is_long(op);
    end

    // R2: folded opcode is always legal
    always_comb a_r2_fold_range: assert (op <= OP_W'(MAX_OP));
endmodule

// File: rtl/cmdrx_ack.sv
module cmdrx_ack #(
    parameter int ACK_W = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hello_in,
    input  logic done_fire,
    output logic ack_n
);
    localparam int CW = $clog2(ACK_W + 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (hello_in) armed_q <= 1'b1;
            if (done_fire && armed_q) cnt_q <= CW'(ACK_W);
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ack_n = (cnt_q == '0);

    // R6: no acknowledge while unarmed
    a_r6_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> ack_n);
    // R7: a pulse only starts after a completion
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(done_fire));
endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
    import cmdrx_pkg::*;
#(
    parameter int ACK_W       = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      rx_data,
    input  logic            rx_strobe_n,
    input  logic            exec_done,
    output logic            cmd_valid,
    output logic [OP_W-1:0] cmd_op,
    output logic [15:0]     cmd_arg,
    output logic            dir_fwd,
    output logic            ack_n,
    output logic            overflow
);
    rx_state_t       state_q, state_d;
    logic            byte_stb;
    logic [OP_W-1:0] dec_op;
    logic            dec_long;
    logic [OP_W-1:0] op_q;
    logic [7:0]      hi_q;
    logic [15:0]     arg_q;
    logic            dir_q, ovf_q;
    logic            hello_now, done_fire;

    cmdrx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(rx_strobe_n), .fall(byte_stb)
    );

    cmdrx_decode u_dec (
        .byte_in(rx_data), .op(dec_op), .long_frame(dec_long)
    );

    assign hello_now = (state_q == ST_WAIT_OP) && byte_stb && (dec_op == OP_W'(2));
    assign done_fire = (state_q == ST_PENDING) && exec_done;

    cmdrx_ack #(.ACK_W(ACK_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .hello_in(hello_now),
        .done_fire(done_fire), .ack_n(ack_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_OP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_OP: if (byte_stb) state_d = dec_long ? ST_WAIT_HI : ST_PENDING;
            ST_WAIT_HI: if (byte_stb) state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (byte_stb) state_d = ST_PENDING;
            ST_PENDING: if (exec_done) state_d = ST_WAIT_OP;
        endcase
    end

    // outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            hi_q  <= '0;
            arg_q <= '0;
            dir_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT_OP: if (byte_stb) begin
                    op_q  <= dec_op;
                    arg_q <= '0;
                end
                ST_WAIT_HI: if (byte_stb) hi_q <= rx_data;
                ST_WAIT_LO: if (byte_stb) begin
                    arg_q <= {hi_q, rx_data};
                    if (op_q == OP_W'(4)) dir_q <= ~hi_q[7];
                end
                ST_PENDING: if (byte_stb) ovf_q <= 1'b1;
            endcase
        end
    end

    assign cmd_valid = (state_q == ST_PENDING);
    assign cmd_op    = op_q;
    assign cmd_arg   = arg_q;
    assign dir_fwd   = dir_q;
    assign overflow  = ovf_q;

    // R5: pending command held stable until done
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !exec_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_arg)));
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && exec_done) |=> !cmd_valid);
    // R4: short commands carry a zero operand
    a_r4_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_valid) && !op_is_long(cmd_op)) |-> (cmd_arg == 16'h0));
    // R8: direction follows operand sign on opcode 4
    a_r8_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_valid) && cmd_op == OP_W'(4)) |-> (dir_fwd == ~cmd_arg[15]));
    // R9: overflow is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R2: presented opcode is legal
    a_r2_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op <= OP_W'(MAX_OP)));
endmodule

// File: tb/cmdrx_top_bench.sv
module cmdrx_top_bench;
    localparam int ACKW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_strobe_n = 1'b1;
    logic        exec_done = 1'b0;
    logic        cmd_valid, dir_fwd, ack_n, overflow;
    logic [4:0]  cmd_op;
    logic [15:0] cmd_arg;

    always #10 clk = ~clk;

    cmdrx_top #(.ACK_W(ACKW), .SYNC_STAGES(2)) u_cmdrx_top (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_strobe_n(rx_strobe_n),
        .exec_done(exec_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .dir_fwd(dir_fwd), .ack_n(ack_n), .overflow(overflow)
    );

    typedef struct packed { logic [4:0] op; logic [15:0] arg; } exp_t;
    exp_t exp_q[$];

    int  checks = 0, errors = 0;
    int  pushed = 0, handled = 0;
    int  acks_seen = 0, acks_exp = 0;
    bit  armed_b = 0, hold_done = 0, finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int low_cycles);
        @(negedge clk);
        rx_data     = b;
        rx_strobe_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        rx_strobe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        armed_b = 0;
    endtask

    // driver: push expected item, send frame, wait for completion, check ack count
    task automatic send_cmd(input logic [7:0] raw, input logic [15:0] arg, input int low_cycles);
        exp_t e;
        bit   lng;
        e.op  = (raw > 8'h13) ? 5'd0 : raw[4:0];
        lng   = (e.op == 5'd3) || (e.op == 5'd4) || (e.op == 5'h13);
        e.arg = lng ? arg : 16'h0;
        exp_q.push_back(e);
        pushed++;
        send_byte(raw, low_cycles);
        if (lng) begin
            check(!cmd_valid, "R3", "valid after byte 1 of long frame", cmd_valid, 0);
            send_byte(arg[15:8], low_cycles);
            check(!cmd_valid, "R3", "valid after byte 2 of long frame", cmd_valid, 0);
            send_byte(arg[7:0], low_cycles);
        end
        while (handled < pushed) @(negedge clk);
        if (armed_b) acks_exp++;
        else if (e.op == 5'd2) begin armed_b = 1; acks_exp++; end
        repeat (ACKW + 4) @(negedge clk);
        check(acks_seen == acks_exp, armed_b ? "R7" : "R6", "ack pulse count", acks_seen, acks_exp);
    endtask

    // monitor: pop and compare each presented command, then complete it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                exp_t e;
                logic [4:0]  op0;
                logic [15:0] arg0;
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected command op", cmd_op, 0);
                    e = '0;
                end else e = exp_q.pop_front();
                check(cmd_op == e.op, "R2", "opcode", cmd_op, e.op);
                check(cmd_arg == e.arg, "R4", "operand", cmd_arg, e.arg);
                if (e.op == 5'd4)
                    check(dir_fwd == ~e.arg[15], "R8", "direction", dir_fwd, ~e.arg[15]);
                op0 = cmd_op; arg0 = cmd_arg;
                while (hold_done) @(negedge clk);
                repeat (3) @(negedge clk);
                check(cmd_valid && cmd_op == op0 && cmd_arg == arg0, "R5",
                      "held before done", {cmd_valid, cmd_op}, {1'b1, op0});
                exec_done = 1'b1;
                @(negedge clk);
                exec_done = 1'b0;
                check(!cmd_valid, "R5", "valid after done", cmd_valid, 0);
                handled++;
            end
        end
    end

    // ack monitor: count low pulses and their width
    initial begin
        int low = 0;
        forever begin
            @(negedge clk);
            if (!ack_n) low++;
            else if (low > 0) begin
                check(low == ACKW, "R7", "ack pulse width", low, ACKW);
                acks_seen++;
                low = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && ack_n && !overflow && !dir_fwd, "R10", "reset outputs",
              {cmd_valid, ack_n, overflow, dir_fwd}, 4'b0100);

        send_cmd(8'h01, 16'h0, 4);          // R6 short, unarmed
        send_cmd(8'h03, 16'h04D2, 4);       // R3 R4 search frame
        send_cmd(8'h20, 16'h0, 4);          // R2 fold
        send_cmd(8'hFF, 16'h0, 4);          // R2 fold
        send_cmd(8'h14, 16'h0, 4);          // R2 just over the limit
        send_cmd(8'h02, 16'h0, 4);          // R7 hello, acked at its own done
        send_cmd(8'h04, 16'h8000, 4);       // R8 reverse
        send_cmd(8'h04, 16'h7FFF, 4);       // R8 forward
        send_cmd(8'h13, 16'hBEEF, 25);      // R1 long strobe, R3 long opcode
        send_cmd(8'h05, 16'h0, 4);
        check(dir_fwd == 1'b1, "R8", "direction kept by other opcode", dir_fwd, 1);

        // R9: byte during pending is dropped
        hold_done = 1;
        exp_q.push_back('{op: 5'd6, arg: 16'h0});
        pushed++;
        send_byte(8'h06, 4);
        check(cmd_valid && cmd_op == 5'd6, "R9", "pending before extra byte", cmd_op, 6);
        send_byte(8'h07, 4);
        check(overflow == 1'b1, "R9", "overflow set", overflow, 1);
        check(cmd_op == 5'd6, "R9", "extra byte ignored", cmd_op, 6);
        hold_done = 0;
        while (handled < pushed) @(negedge clk);
        acks_exp++;
        repeat (ACKW + 4) @(negedge clk);
        check(acks_seen == acks_exp, "R7", "ack after overflowed command", acks_seen, acks_exp);
        send_cmd(8'h08, 16'h0, 4);
        check(overflow == 1'b1, "R9", "overflow sticky", overflow, 1);

        // R10: reset drops a partial frame and disarms
        send_byte(8'h03, 4);
        send_byte(8'h12, 4);
        do_reset();
        @(negedge clk);
        check(!cmd_valid && !overflow && !dir_fwd && ack_n, "R10", "outputs after reset",
              {cmd_valid, ack_n, overflow, dir_fwd}, 4'b0100);
        send_cmd(8'h01, 16'h0, 4);          // R10 partial frame gone, no ack

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule